// File: doc/BRIEF.md
# DRAM Bank Command Sequencer

This block drives one DRAM bank. It takes read and write requests, one at a time, through a valid/ready port. Each request carries a row, a column, a direction and a hint to close the row after the access. The block turns each request into the commands the bank needs: an activate to open the row, a column read or write (plain, or with auto-precharge), and an explicit precharge when a different row must be opened. It places each command at the earliest clock cycle that the minimum row timings allow. It tracks which row is open, so further accesses to that row need only a column command.

For every column command the block also produces a window marker for the data path. For reads, the marker sits at a fixed number of cycles after the command. For writes, it sits at the write latency after the command. Each window is as long as one burst. A command-rate input selects whether each command takes one or two bus cycles. All timing values are parameters counted in clock cycles.

Top module: `bank_cmd_seq`

## Requirements
- R1: After reset, no row is open, `req_ready` is 1, `cmd_code` is NOP and both data windows are low. A request accepted on a clock edge with the bank closed and idle produces ACTIVATE in the very next cycle.
- R2: The command codes are NOP=0, ACTIVATE=1, READ=2, READ+auto-precharge=3, WRITE=4, WRITE+auto-precharge=5, PRECHARGE=6. An access to a closed bank issues ACTIVATE with the row on `cmd_addr`, then the column command with the column zero-extended on `cmd_addr`.
- R3: A column command comes at least T_RCD cycles after the ACTIVATE of its row. When nothing else blocks it, it comes exactly T_RCD cycles after.
- R4: `rd_valid` is high for exactly BURST_CYC consecutive cycles, starting RD_LAT cycles after each READ or READ+auto-precharge.
- R5: `wr_en` is high for exactly BURST_CYC consecutive cycles, starting WR_LAT cycles after each WRITE or WRITE+auto-precharge.
- R6: A request to the row that is already open issues only a column command, with no ACTIVATE.
- R7: After an auto-precharge column command the row counts as closed. The next ACTIVATE comes exactly T_RP cycles after the later of two points: ACTIVATE+T_RAS, and the cycle after the last data cycle of that burst. This holds when a request is waiting.
- R8: A request to a different row while a row is open issues PRECHARGE, then ACTIVATE. PRECHARGE comes at the earliest cycle that is at least T_RAS after ACTIVATE and after the last data cycle. The following ACTIVATE comes exactly T_RP cycles after PRECHARGE.
- R9: With `cmd_2t` high, the cycle after any command carries NOP and holds `cmd_addr` unchanged.
- R10: Column commands are at least BURST_CYC cycles apart, with exact spacing for same-direction reads in a row. A column command that changes direction waits until both data windows have ended. `rd_valid` and `wr_en` are never high together.
- R11: `req_ready` is low while a request is held. Every accepted request is served in order with the fields captured at the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_2t | input | 1 | 1 = two-cycle command slot, 0 = one cycle |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_row | input | ROW_W | Row of the request |
| req_col | input | COL_W | Column of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_autopre | input | 1 | Close the row after this access |
| cmd_code | output | 3 | Command issued this cycle |
| cmd_addr | output | max(ROW_W,COL_W) | Address for the command |
| rd_valid | output | 1 | Read data window |
| wr_en | output | 1 | Write data window |

## Verification
The hardest situations to reach are those where the data window, not the row timers, decides when a command may go. Examples are a precharge waiting for a write burst to drain, an implicit close after an auto-precharge read, and a write that follows a read on the same row. Directed sequences reach them by offering the next request in the very cycle `req_ready` rises, so each request meets the previous burst still in flight. Random traffic over three rows, with mixed directions, auto-precharge hints and both command rates, then checks every command against minimum spacings and checks every cycle of both windows.

// File: rtl/bank_seq_pkg.sv
`timescale 1ns/1ps
// Shared command encoding for the bank command sequencer.
// Assumes a 3-bit command field decoded by the bank interface.
package bank_seq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_RDA = 3'd3,
        CMD_WR  = 3'd4,
        CMD_WRA = 3'd5,
        CMD_PRE = 3'd6
    } bank_cmd_e;

endpackage

// File: rtl/bank_min_timer.sv
`timescale 1ns/1ps
// Minimum-spacing timer: after a start pulse in cycle n, ready is low
// until cycle n+MIN. Assumes MIN >= 1.
module bank_min_timer #(
    parameter int MIN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ready
);
    localparam int CW = (MIN > 1) ? $clog2(MIN + 1) : 1;

    logic [CW-1:0] remain;

    // Load on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (start) begin
            remain <= CW'(MIN - 1);
        end else if (remain != '0) begin
            remain <= remain - CW'(1);
        end
    end

    assign ready = (remain == '0);

endmodule

// File: rtl/bank_data_window.sv
`timescale 1ns/1ps
// Data window generator: a launch in cycle n raises active for cycles
// n+LAT .. n+LAT+BURST-1. Launches must be at least BURST apart.
// busy stays high from the cycle after launch through the last data cycle.
module bank_data_window #(
    parameter int LAT   = 5,
    parameter int BURST = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    output logic active,
    output logic busy
);
    localparam int CW = $clog2(BURST + 1);

    logic [LAT-1:0] dly;
    logic [CW-1:0]  left;
    logic           tail;

    generate
        if (LAT == 1) begin : g_single
            // Single-stage latency register.
            always_ff @(posedge clk) begin
                if (!rst_n) dly <= '0;
                else        dly <= launch;
            end
        end else begin : g_chain
            // Latency shift chain, one stage per cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) dly <= '0;
                else        dly <= {dly[LAT-2:0], launch};
            end
        end
    endgenerate

    assign tail = dly[LAT-1];

    // Remaining burst cycles after the first data cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left <= '0;
        end else if (tail) begin
            left <= CW'(BURST - 1);
        end else if (left != '0) begin
            left <= left - CW'(1);
        end
    end

    assign active = tail | (left != '0);
    assign busy   = (|dly) | (left != '0);

endmodule

// File: rtl/bank_cmd_seq.sv
`timescale 1ns/1ps
// Per-bank command sequencer. It holds one request and issues ACTIVATE,
// column and PRECHARGE commands at the earliest legal cycle. It tracks
// the open row and drives the read and write data windows.
// Assumes every timing parameter >= 1 and BURST_CYC >= 1.
module bank_cmd_seq
    import bank_seq_pkg::*;
#(
    parameter int ROW_W     = 14,
    parameter int COL_W     = 10,
    parameter int T_RCD     = 3,
    parameter int T_RAS     = 8,
    parameter int T_RP      = 3,
    parameter int RD_LAT    = 5,
    parameter int WR_LAT    = 4,
    parameter int BURST_CYC = 4,
    localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_2t,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_write,
    input  logic              req_autopre,
    output logic [2:0]        cmd_code,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              rd_valid,
    output logic              wr_en
);
    // Held request
    logic             pend_valid;
    logic [ROW_W-1:0] pend_row;
    logic [COL_W-1:0] pend_col;
    logic             pend_write;
    logic             pend_ap;

    // Bank state
    logic              row_open;
    logic [ROW_W-1:0]  open_row;
    logic              closing;
    logic              hold_q;
    logic [ADDR_W-1:0] addr_q;
    logic              last_write;

    // Timer and window status
    logic rcd_ok, ras_ok, rp_ok, ccd_ok;
    logic rd_busy, wr_busy, pipe_idle;

    // Decisions
    logic row_hit, want_act, want_pre, want_col;
    logic fire_act, fire_pre, fire_col, fire_any, implicit_pre;
    logic accept;
    bank_cmd_e cmd_now;

    assign accept    = req_valid && !pend_valid;
    assign req_ready = !pend_valid;
    assign pipe_idle = !rd_busy && !wr_busy;

    assign row_hit  = row_open && (open_row == pend_row);
    assign want_act = pend_valid && !row_open && !closing;
    assign want_pre = pend_valid && row_open && !row_hit;
    assign want_col = pend_valid && row_hit;

    assign fire_act = want_act && !hold_q && rp_ok;
    assign fire_pre = want_pre && !hold_q && ras_ok && pipe_idle;
    assign fire_col = want_col && !hold_q && rcd_ok && ccd_ok &&
                      ((pend_write == last_write) || pipe_idle);
    assign fire_any = fire_act || fire_pre || fire_col;
    assign implicit_pre = closing && ras_ok && pipe_idle;

    // Row timing: ACTIVATE to column, ACTIVATE to precharge, precharge to ACTIVATE.
    bank_min_timer #(.MIN(T_RCD)) u_rcd (
        .clk(clk), .rst_n(rst_n), .start(fire_act), .ready(rcd_ok));
    bank_min_timer #(.MIN(T_RAS)) u_ras (
        .clk(clk), .rst_n(rst_n), .start(fire_act), .ready(ras_ok));
    bank_min_timer #(.MIN(T_RP)) u_rp (
        .clk(clk), .rst_n(rst_n), .start(fire_pre || implicit_pre), .ready(rp_ok));
    bank_min_timer #(.MIN(BURST_CYC)) u_ccd (
        .clk(clk), .rst_n(rst_n), .start(fire_col), .ready(ccd_ok));

    // Data windows for read and write bursts.
    bank_data_window #(.LAT(RD_LAT), .BURST(BURST_CYC)) u_rd_win (
        .clk(clk), .rst_n(rst_n), .launch(fire_col && !pend_write),
        .active(rd_valid), .busy(rd_busy));
    bank_data_window #(.LAT(WR_LAT), .BURST(BURST_CYC)) u_wr_win (
        .clk(clk), .rst_n(rst_n), .launch(fire_col && pend_write),
        .active(wr_en), .busy(wr_busy));

    // Command code selection for this cycle.
    always_comb begin
        cmd_now = CMD_NOP;
        if (fire_act) begin
            cmd_now = CMD_ACT;
        end else if (fire_pre) begin
            cmd_now = CMD_PRE;
        end else if (fire_col) begin
            case ({pend_write, pend_ap})
                2'b00:   cmd_now = CMD_RD;
                2'b01:   cmd_now = CMD_RDA;
                2'b10:   cmd_now = CMD_WR;
                default: cmd_now = CMD_WRA;
            endcase
        end
    end

    assign cmd_code = cmd_now;

    // Address bus: row, column, held address in a 2T slot, else zero.
    always_comb begin
        if (fire_act)      cmd_addr = ADDR_W'(pend_row);
        else if (fire_col) cmd_addr = ADDR_W'(pend_col);
        else if (hold_q)   cmd_addr = addr_q;
        else               cmd_addr = '0;
    end

    // Request holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_row   <= '0;
            pend_col   <= '0;
            pend_write <= 1'b0;
            pend_ap    <= 1'b0;
        end else if (accept) begin
            pend_valid <= 1'b1;
            pend_row   <= req_row;
            pend_col   <= req_col;
            pend_write <= req_write;
            pend_ap    <= req_autopre;
        end else if (fire_col) begin
            pend_valid <= 1'b0;
        end
    end

    // Open-row tracking, including the auto-precharge closing phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_open <= 1'b0;
            open_row <= '0;
            closing  <= 1'b0;
        end else begin
            if (fire_act) begin
                row_open <= 1'b1;
                open_row <= pend_row;
            end else if (fire_pre || (fire_col && pend_ap)) begin
                row_open <= 1'b0;
            end
            if (fire_col && pend_ap)  closing <= 1'b1;
            else if (implicit_pre)    closing <= 1'b0;
        end
    end

    // Command-rate hold and last column direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q     <= 1'b0;
            addr_q     <= '0;
            last_write <= 1'b0;
        end else begin
            hold_q <= fire_any && cmd_2t;
            if (fire_any) addr_q     <= cmd_addr;
            if (fire_col) last_write <= pend_write;
        end
    end

endmodule

// File: rtl/bank_cmd_seq_chk.sv
`timescale 1ns/1ps
// Protocol checker for bank_cmd_seq: command spacing, bus hold and
// window exclusion, checked through cycle counters at the ports.
module bank_cmd_seq_chk #(
    parameter int T_RCD     = 3,
    parameter int T_RAS     = 8,
    parameter int T_RP      = 3,
    parameter int BURST_CYC = 4,
    parameter int ADDR_W    = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_2t,
    input logic              req_valid,
    input logic              req_ready,
    input logic [2:0]        cmd_code,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              rd_valid,
    input logic              wr_en
);
    logic [31:0] since_act, since_pre, since_col;
    logic is_col;

    assign is_col = (cmd_code >= 3'd2) && (cmd_code <= 3'd5);

    // Cycles since the last ACTIVATE, PRECHARGE and column command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_act <= 32'hFFFF_FFFF;
            since_pre <= 32'hFFFF_FFFF;
            since_col <= 32'hFFFF_FFFF;
        end else begin
            since_act <= (cmd_code == 3'd1) ? 32'd1 :
                         (since_act == 32'hFFFF_FFFF) ? since_act : since_act + 32'd1;
            since_pre <= (cmd_code == 3'd6) ? 32'd1 :
                         (since_pre == 32'hFFFF_FFFF) ? since_pre : since_pre + 32'd1;
            since_col <= is_col ? 32'd1 :
                         (since_col == 32'hFFFF_FFFF) ? since_col : since_col + 32'd1;
        end
    end

    // R3
    rcd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |-> (since_act >= 32'(T_RCD)));

    // R8
    ras_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == 3'd6) |-> (since_act >= 32'(T_RAS)));

    // R8
    rp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == 3'd1) |-> (since_pre >= 32'(T_RP)));

    // R10
    col_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |-> (since_col >= 32'(BURST_CYC)));

    // R10
    bus_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && wr_en));

    // R9
    hold_2t_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_code != 3'd0) && cmd_2t) |=> ((cmd_code == 3'd0) && $stable(cmd_addr)));

    // R11
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

bind bank_cmd_seq bank_cmd_seq_chk #(
    .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP),
    .BURST_CYC(BURST_CYC), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_2t(cmd_2t),
    .req_valid(req_valid), .req_ready(req_ready),
    .cmd_code(cmd_code), .cmd_addr(cmd_addr),
    .rd_valid(rd_valid), .wr_en(wr_en)
);

// File: tb/bank_cmd_seq_test.sv
`timescale 1ns/1ps
module bank_cmd_seq_test;
    localparam int ROW_W = 14, COL_W = 10;
    localparam int T_RCD = 3, T_RAS = 8, T_RP = 3;
    localparam int RD_LAT = 5, WR_LAT = 4, BURST_CYC = 4;
    localparam int ADDR_W = 14;

    logic clk = 1'b0, rst_n = 1'b0, tb_2t = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_autopre = 1'b0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic req_ready, rd_valid, wr_en;
    logic [2:0] cmd_code;
    logic [ADDR_W-1:0] cmd_addr;

    bank_cmd_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .T_RCD(T_RCD), .T_RAS(T_RAS),
        .T_RP(T_RP), .RD_LAT(RD_LAT), .WR_LAT(WR_LAT), .BURST_CYC(BURST_CYC)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_2t(tb_2t), .req_valid(req_valid),
        .req_ready(req_ready), .req_row(req_row), .req_col(req_col),
        .req_write(req_write), .req_autopre(req_autopre), .cmd_code(cmd_code),
        .cmd_addr(cmd_addr), .rd_valid(rd_valid), .wr_en(wr_en));

    always #2 clk = ~clk;

    int cyc = 0, checks = 0, fails = 0, acc = 0;
    int q_row[$], q_col[$], q_wr[$], q_ap[$];
    bit exp_rd[256], exp_wr[256];
    int last_act = -1000, last_pre = -1000, last_col = -1000, last_wend = -1000;
    int imp_bound = 0, prev_addr = 0, last_dir = 0, b_row = 0;
    bit b_open = 0, col_seen = 0, prev_cmd = 0, prev_2t = 0;

    function automatic int mx(int a, int b);
        return (a > b) ? a : b;
    endfunction

    task automatic chk(bit ok, string r, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", r, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Monitor: command legality, order, spacing and per-cycle windows.
    always @(negedge clk) begin
        if (rst_n) begin
            int n, c, code, lat;
            n = cyc;
            c = int'(cmd_code);
            chk(rd_valid == exp_rd[n % 256], "R4 rd_valid", int'(rd_valid), int'(exp_rd[n % 256]));
            chk(wr_en == exp_wr[n % 256], "R5 wr_en", int'(wr_en), int'(exp_wr[n % 256]));
            exp_rd[n % 256] = 0;
            exp_wr[n % 256] = 0;
            if (prev_cmd && prev_2t)
                chk(c == 0 && int'(cmd_addr) == prev_addr, "R9 hold", int'(cmd_addr), prev_addr);
            if (c != 0 && q_row.size() == 0) chk(0, "R11 unrequested cmd", c, 0);
            else if (c == 1) begin
                chk(!b_open, "R2 act while open", 1, 0);
                chk(int'(cmd_addr) == q_row[0], "R2 act row", int'(cmd_addr), q_row[0]);
                chk(n - last_pre >= T_RP, "R8 tRP", n - last_pre, T_RP);
                chk(n >= imp_bound, "R7 reopen", n, imp_bound);
                b_open = 1; b_row = q_row[0]; last_act = n;
            end else if (c == 6) begin
                chk(b_open && q_row[0] != b_row, "R8 pre need", b_row, q_row[0]);
                chk(n - last_act >= T_RAS, "R8 tRAS", n - last_act, T_RAS);
                chk(n > last_wend, "R8 pre vs data", n, last_wend + 1);
                b_open = 0; last_pre = n; imp_bound = n + T_RP;
            end else if (c >= 2 && c <= 5) begin
                code = 2 + (q_wr[0] != 0 ? 2 : 0) + (q_ap[0] != 0 ? 1 : 0);
                chk(b_open && b_row == q_row[0], "R6 row hit", b_row, q_row[0]);
                chk(c == code, "R2 col code", c, code);
                chk(int'(cmd_addr) == q_col[0], "R2 col addr", int'(cmd_addr), q_col[0]);
                chk(n - last_act >= T_RCD, "R3 tRCD", n - last_act, T_RCD);
                chk(n - last_col >= BURST_CYC, "R10 col gap", n - last_col, BURST_CYC);
                if (col_seen && last_dir != q_wr[0])
                    chk(n > last_wend, "R10 turnaround", n, last_wend + 1);
                lat = (q_wr[0] != 0) ? WR_LAT : RD_LAT;
                for (int k = 0; k < BURST_CYC; k++) begin
                    if (q_wr[0] != 0) exp_wr[(n + lat + k) % 256] = 1;
                    else              exp_rd[(n + lat + k) % 256] = 1;
                end
                last_wend = n + lat + BURST_CYC - 1;
                last_col = n; last_dir = q_wr[0]; col_seen = 1;
                if (q_ap[0] != 0) begin
                    b_open = 0;
                    imp_bound = mx(last_act + T_RAS, last_wend + 1) + T_RP;
                end
                void'(q_row.pop_front()); void'(q_col.pop_front());
                void'(q_wr.pop_front());  void'(q_ap.pop_front());
            end else if (c != 0) chk(0, "R2 illegal code", c, 0);
            prev_cmd = (c != 0);
            prev_addr = int'(cmd_addr);
            prev_2t = tb_2t;
        end
    end

    // Offer a request; returns at the negedge after the handshake.
    task automatic send(int row, int col, bit wr, bit ap);
        req_row = ROW_W'(row); req_col = COL_W'(col);
        req_write = wr; req_autopre = ap; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        acc = cyc;
        q_row.push_back(row); q_col.push_back(col);
        q_wr.push_back(int'(wr)); q_ap.push_back(int'(ap));
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        int a2, a3, a4, act1, col3, act4, col4, pre4, ca, cb, cc;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        chk(cmd_code == 3'd0, "R1 cmd", int'(cmd_code), 0);
        chk(!rd_valid && !wr_en, "R1 windows", int'(rd_valid | wr_en), 0);

        // R1, R2, R3: closed bank, exact ACT and column placement
        send(14'h123, 10'h040, 0, 0); a2 = acc;
        repeat (20) @(negedge clk);
        chk(last_act == a2 + 1, "R1 first act", last_act, a2 + 1);
        chk(last_col - last_act == T_RCD, "R3 exact", last_col - last_act, T_RCD);
        act1 = last_act;

        // R6 row hit, R8 precharge gated by write window
        send(14'h123, 10'h048, 1, 0); a3 = acc;
        send(14'h200, 10'h010, 0, 1); a4 = acc;
        col3 = last_col;
        chk(col3 == a3 + 1, "R6 col only", col3, a3 + 1);
        send(14'h200, 10'h018, 0, 0);
        act4 = last_act; col4 = last_col; pre4 = last_pre;
        chk(act4 != act1 && last_act > col3, "R8 new act", act4, col3);
        chk(pre4 == mx(mx(a4 + 1, col3 + WR_LAT + BURST_CYC), act1 + T_RAS), "R8 pre exact",
            pre4, mx(mx(a4 + 1, col3 + WR_LAT + BURST_CYC), act1 + T_RAS));
        chk(act4 - pre4 == T_RP, "R8 act after pre", act4 - pre4, T_RP);

        // R7 reopen after auto-precharge read
        repeat (30) @(negedge clk);
        chk(last_act == mx(act4 + T_RAS, col4 + RD_LAT + BURST_CYC) + T_RP, "R7 reopen exact",
            last_act, mx(act4 + T_RAS, col4 + RD_LAT + BURST_CYC) + T_RP);

        // R10 read-read spacing and read-write turnaround
        send(14'h200, 10'h020, 0, 0);
        send(14'h200, 10'h028, 0, 0); ca = last_col;
        send(14'h200, 10'h030, 1, 0); cb = last_col;
        repeat (30) @(negedge clk); cc = last_col;
        chk(cb - ca == BURST_CYC, "R10 rd-rd", cb - ca, BURST_CYC);
        chk(cc - cb == RD_LAT + BURST_CYC, "R10 rd-wr", cc - cb, RD_LAT + BURST_CYC);

        // R9 two-cycle command slots
        tb_2t = 1'b1;
        send(14'h300, 10'h005, 1, 1);
        repeat (30) @(negedge clk);
        chk(last_act - last_pre == T_RP, "R9 2T pre-act", last_act - last_pre, T_RP);
        chk(last_col - last_act == T_RCD, "R9 2T act-col", last_col - last_act, T_RCD);
        send(14'h300, 10'h006, 0, 0);
        send(14'h300, 10'h00E, 0, 1);
        repeat (30) @(negedge clk);
        tb_2t = 1'b0;

        // Random traffic over three rows, both command rates
        for (int i = 0; i < 400; i++) begin
            int r, sel;
            if (i % 50 == 0) begin
                repeat (40) @(negedge clk);
                tb_2t = ($urandom % 2) != 0;
            end
            sel = $urandom % 3;
            r = (sel == 0) ? 14'h010 : (sel == 1) ? 14'h011 : 14'h3FF;
            send(r, $urandom % 1024, ($urandom % 2) != 0, ($urandom % 4) == 0);
            repeat ($urandom % 4) @(negedge clk);
        end
        repeat (40) @(negedge clk);
        chk(q_row.size() == 0, "R11 all served", q_row.size(), 0);
        chk(req_ready == 1'b1, "R11 idle ready", int'(req_ready), 1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule